// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit turns the operand fields of a decoded memory-referencing instruction into a byte address. Each accepted request gives it a base value, an index value, a two-bit scale code, a two-bit operand mode and up to four displacement bytes. The displacement bytes have already been taken from the instruction stream.

The index is shifted left by the scale code, never multiplied. The displacement is sign-extended to the working width. The three terms are added in a datapath wide enough that no carry or shifted-out bit is lost before the end. The sum is then cut down to the selected address size, either 32 or 16 bits.

The mode code chooses between a register operand and three memory forms that differ only in displacement size. For a register operand the unit reports that no address exists. Results appear on registered outputs one clock after the request.

Top module: `eag_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the next state has `out_valid` = 0, `out_is_reg` = 0 and `out_addr` = 0.
- R2: A request with `in_valid` = 1 at a rising edge is reflected on the outputs right after that same edge. An edge with `in_valid` = 0 leaves `out_valid` = 0 and `out_is_reg` = 0.
- R3: The index term is `index` shifted left by `scale` (0..3), so the multipliers are 1, 2, 4 and 8. With base 3, index 10 and scale 1 the address is 23.
- R4: `mode` = 2'b00 is memory with no displacement. All of `disp_raw` is ignored.
- R5: `mode` = 2'b01 is memory with an 8-bit displacement. `disp_raw[7:0]` is sign-extended and bits 31:8 are ignored. 0xFF subtracts 1 and 0x80 subtracts 128.
- R6: `mode` = 2'b10 is memory with a 32-bit displacement. All of `disp_raw` is used as a signed value, with byte 0 in bits 7:0.
- R7: `mode` = 2'b11 is a register operand. It gives `out_is_reg` = 1, `out_valid` = 0 and `out_addr` = 0.
- R8: With `asize` = 1 the sum is truncated to 32 bits. An intermediate sum of 0x2_12345678 yields 0x12345678.
- R9: With `asize` = 0 the sum is truncated to 16 bits and `out_addr[31:16]` = 0. The 8-bit displacement is still sign-extended before truncation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| mode | input | 2 | Operand mode: 00 no disp, 01 disp8, 10 disp32, 11 register |
| scale | input | 2 | Index shift count 0..3 |
| asize | input | 1 | Address size: 1 = 32-bit, 0 = 16-bit |
| base | input | 32 | Base register value |
| index | input | 32 | Index register value |
| disp_raw | input | 32 | Displacement bytes, byte 0 in bits 7:0 |
| out_valid | output | 1 | Memory address available |
| out_is_reg | output | 1 | Operand is a register, no address |
| out_addr | output | 32 | Truncated effective address |

## Verification
Almost all of the logic is combinational, so any fault reaches `out_addr` in the cycle right after the request. Faults that can show up there include:
- a wrong sign-extension boundary;
- a shift that is off by one;
- a mask that is too wide or too narrow;
- a carry dropped too early.

A fault in the output flags shows up as a wrong `out_valid`/`out_is_reg` pair on that same edge. The cases chosen to expose these faults are random requests, negative displacements that cross zero, and sums that overflow either address size.

// File: rtl/eag_pkg.sv
package eag_pkg;

  typedef enum logic [1:0] {
    EA_NODISP = 2'b00,
    EA_DISP8  = 2'b01,
    EA_DISP32 = 2'b10,
    EA_REGOP  = 2'b11
  } ea_mode_e;

  function automatic logic mode_is_mem(input ea_mode_e m);
    return m != EA_REGOP;
  endfunction

endpackage

// File: rtl/eag_disp_ext.sv
module eag_disp_ext
  import eag_pkg::*;
#(
  parameter int DISP_W = 32,
  parameter int SHORT_W = 8,
  parameter int CALC_W = 36
) (
  input  ea_mode_e            mode,
  input  logic [DISP_W-1:0]   disp_raw,
  output logic [CALC_W-1:0]   disp_ext
);

  logic [CALC_W-1:0] ext_short;
  logic [CALC_W-1:0] ext_long;

  assign ext_short = {{(CALC_W-SHORT_W){disp_raw[SHORT_W-1]}}, disp_raw[SHORT_W-1:0]};
  assign ext_long  = {{(CALC_W-DISP_W){disp_raw[DISP_W-1]}}, disp_raw};

  always_comb begin
    unique case (mode)
      EA_DISP8:  disp_ext = ext_short;
      EA_DISP32: disp_ext = ext_long;
      default:   disp_ext = '0;
    endcase
  end

  // R4 and R5 guards: no displacement means zero, the short form carries its sign upward
  always_comb begin
    if (mode == EA_NODISP)
      a_r4_no_disp: assert (disp_ext == '0) else $error("R4 displacement leaked");
    if (mode == EA_DISP8)
      a_r5_short_sign: assert ($signed(disp_ext) == $signed(disp_raw[SHORT_W-1:0]))
        else $error("R5 short displacement sign");
  end

endmodule

// File: rtl/eag_scaler.sv
module eag_scaler #(
  parameter int ADDR_W = 32,
  parameter int SCALE_W = 2,
  parameter int CALC_W = 36
) (
  input  logic [ADDR_W-1:0]  index,
  input  logic [SCALE_W-1:0] scale,
  output logic [CALC_W-1:0]  scaled
);

  logic [CALC_W-1:0] index_wide;
  assign index_wide = CALC_W'(index);
  assign scaled = index_wide << scale;

  // R3 guard: shifting back recovers the index with nothing lost
  always_comb begin
    a_r3_shift_lossless: assert ((scaled >> scale) == index_wide)
      else $error("R3 index bits lost in shift");
  end

endmodule

// File: rtl/eag_sum_mask.sv
module eag_sum_mask #(
  parameter int ADDR_W = 32,
  parameter int NARROW_W = 16,
  parameter int CALC_W = 36
) (
  input  logic [CALC_W-1:0] base_wide,
  input  logic [CALC_W-1:0] idx_term,
  input  logic [CALC_W-1:0] disp_term,
  input  logic              wide_sel,
  output logic [ADDR_W-1:0] addr
);

  logic [CALC_W-1:0] total;
  assign total = base_wide + idx_term + disp_term;

  generate
    if (NARROW_W < ADDR_W) begin : g_two_sizes
      always_comb begin
        if (wide_sel) addr = total[ADDR_W-1:0];
        else          addr = {{(ADDR_W-NARROW_W){1'b0}}, total[NARROW_W-1:0]};
      end
    end else begin : g_one_size
      assign addr = total[ADDR_W-1:0];
    end
  endgenerate

  // R9 guard: narrow size leaves the upper address bits clear
  always_comb begin
    if (!wide_sel && NARROW_W < ADDR_W)
      a_r9_narrow_upper: assert ((addr >> NARROW_W) == '0)
        else $error("R9 upper bits set in narrow size");
  end

endmodule

// File: rtl/eag_unit.sv
module eag_unit
  import eag_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NARROW_W = 16,
  parameter int DISP_W = 32,
  parameter int SHORT_W = 8,
  parameter int SCALE_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [1:0]         mode,
  input  logic [SCALE_W-1:0] scale,
  input  logic               asize,
  input  logic [ADDR_W-1:0]  base,
  input  logic [ADDR_W-1:0]  index,
  input  logic [DISP_W-1:0]  disp_raw,
  output logic               out_valid,
  output logic               out_is_reg,
  output logic [ADDR_W-1:0]  out_addr
);

  localparam int MAX_SHIFT = (1 << SCALE_W) - 1;
  localparam int CALC_W = ADDR_W + MAX_SHIFT + 1;

  ea_mode_e          mode_e;
  logic [CALC_W-1:0] idx_term;
  logic [CALC_W-1:0] disp_term;
  logic [ADDR_W-1:0] addr_comb;
  logic              is_mem;

  assign mode_e = ea_mode_e'(mode);
  assign is_mem = mode_is_mem(mode_e);

  eag_disp_ext #(.DISP_W(DISP_W), .SHORT_W(SHORT_W), .CALC_W(CALC_W)) u_disp (
    .mode(mode_e), .disp_raw(disp_raw), .disp_ext(disp_term)
  );

  eag_scaler #(.ADDR_W(ADDR_W), .SCALE_W(SCALE_W), .CALC_W(CALC_W)) u_scale (
    .index(index), .scale(scale), .scaled(idx_term)
  );

  eag_sum_mask #(.ADDR_W(ADDR_W), .NARROW_W(NARROW_W), .CALC_W(CALC_W)) u_sum (
    .base_wide(CALC_W'(base)), .idx_term(idx_term), .disp_term(disp_term),
    .wide_sel(asize), .addr(addr_comb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_is_reg <= 1'b0;
      out_addr   <= '0;
    end else begin
      out_valid  <= in_valid && is_mem;
      out_is_reg <= in_valid && !is_mem;
      out_addr   <= (in_valid && is_mem) ? addr_comb : '0;
    end
  end

  a_r7_reg_has_no_addr: assert property (@(posedge clk) disable iff (rst)
    out_is_reg |-> (!out_valid && out_addr == '0));

  a_r2_request_answered: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_valid || out_is_reg));

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !out_is_reg));

  a_r7_reg_mode_flag: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 2'b11) |=> (out_is_reg && !out_valid));

endmodule

// File: tb/sim_eag_unit.sv
`timescale 1ns/100ps
module sim_eag_unit;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [1:0]  mode;
  logic [1:0]  scale;
  logic        asize;
  logic [31:0] base, index, disp_raw;
  logic        out_valid, out_is_reg;
  logic [31:0] out_addr;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  eag_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode), .scale(scale),
    .asize(asize), .base(base), .index(index), .disp_raw(disp_raw),
    .out_valid(out_valid), .out_is_reg(out_is_reg), .out_addr(out_addr)
  );

  function automatic logic [31:0] ref_addr(input logic [1:0] m, input logic [1:0] sc,
                                           input logic az, input logic [31:0] b,
                                           input logic [31:0] i, input logic [31:0] d);
    logic [63:0] s, dx;
    if (m == 2'b11) return 32'h0;
    case (m)
      2'b01:   dx = {{56{d[7]}}, d[7:0]};
      2'b10:   dx = {{32{d[31]}}, d};
      default: dx = 64'h0;
    endcase
    s = {32'h0, b} + ({32'h0, i} << sc) + dx;
    return az ? s[31:0] : {16'h0, s[15:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input string req, input logic [1:0] m, input logic [1:0] sc,
                       input logic az, input logic [31:0] b, input logic [31:0] i,
                       input logic [31:0] d);
    logic [31:0] e;
    @(negedge clk);
    in_valid = 1'b1; mode = m; scale = sc; asize = az;
    base = b; index = i; disp_raw = d;
    e = ref_addr(m, sc, az, b, i, d);
    @(negedge clk);
    in_valid = 1'b0;
    check(req, out_addr, e);
    check(req, {30'h0, out_valid, out_is_reg}, (m == 2'b11) ? 32'h1 : 32'h2);
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #100us;
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    report();
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; in_valid = 1'b0; mode = 2'b00; scale = 2'b00; asize = 1'b1;
    base = '0; index = '0; disp_raw = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", {30'h0, out_valid, out_is_reg}, 32'h0);
    check("R1", out_addr, 32'h0);
    rst = 1'b0;

    // R3 worked example and each shift count
    apply("R3", 2'b00, 2'd1, 1'b1, 32'd3, 32'd10, 32'hDEAD_BEEF);
    check("R3", out_addr, 32'd23);
    for (int s = 0; s < 4; s++) apply("R3", 2'b00, s[1:0], 1'b1, 32'd0, 32'd5, 32'h0);
    // R4 disp ignored
    apply("R4", 2'b00, 2'd0, 1'b1, 32'h1000, 32'h0, 32'hFFFF_FFFF);
    check("R4", out_addr, 32'h1000);
    // R5 short displacement, upper bytes ignored
    apply("R5", 2'b01, 2'd0, 1'b1, 32'd100, 32'd0, 32'h1234_56FF);
    check("R5", out_addr, 32'd99);
    apply("R5", 2'b01, 2'd0, 1'b1, 32'd100, 32'd0, 32'h0000_0080);
    check("R5", out_addr, 32'hFFFF_FFE4);
    // R6 long displacement negative
    apply("R6", 2'b10, 2'd2, 1'b1, 32'h100, 32'h4, 32'hFFFF_FF00);
    check("R6", out_addr, 32'h10);
    // R7 register operand
    apply("R7", 2'b11, 2'd3, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h7F);
    // R8 wrap of 0x2_12345678
    apply("R8", 2'b00, 2'd3, 1'b1, 32'h1234_5678, 32'h4000_0000, 32'h0);
    check("R8", out_addr, 32'h1234_5678);
    // R9 narrow size with sign-extended short displacement
    apply("R9", 2'b01, 2'd0, 1'b0, 32'd100, 32'd0, 32'h80);
    check("R9", out_addr, 32'h0000_FFE4);
    apply("R9", 2'b10, 2'd1, 1'b0, 32'hABCD_FFF0, 32'h8, 32'h0001_0000);
    // R2 idle cycle keeps flags low
    @(negedge clk);
    check("R2", {30'h0, out_valid, out_is_reg}, 32'h0);

    // random mix, all modes/scales/sizes
    for (int k = 0; k < 400; k++) begin
      logic [1:0] rm, rs;
      logic       ra;
      rm = 2'($urandom); rs = 2'($urandom); ra = 1'($urandom);
      apply("R8", rm, rs, ra, $urandom, $urandom, $urandom);
    end

    // R1 reset mid-stream clears outputs
    @(negedge clk);
    in_valid = 1'b1; mode = 2'b00; rst = 1'b1;
    @(negedge clk);
    check("R1", {30'h0, out_valid, out_is_reg}, 32'h0);
    report();
  end

endmodule